// File: doc/BRIEF.md
# Predicated Vector Element Issue Expander

This block sits between instruction decode and a multi-issue instruction FIFO. It accepts one decoded instruction in scalar form. When the effective vector length is above one and at least one of its register fields is marked vectorised in a per-register tag table, it replaces that instruction with a run of element instructions. Each element instruction is identical to the original except for the tagged register numbers, which are offset by the element index. The program counter is held during the whole run, and a single advance pulse releases it at the end.

A predicate mask read from the integer register file gates the elements. That register may still be pending from an earlier instruction, so the expander acts as its own hazard-tracked unit. It waits on a scoreboard ready flag before it issues anything, then captures the mask once. Elements whose predicate bit is clear are never pushed. A find-next-set-bit search lets a disabled element cost no FIFO cycle. Instructions that are not vectorised pass through once, with no predicate wait.

Top module: `vec_elem_expander`

## Requirements
- R1: After reset, out_valid and pc_adv are 0 and in_ready is 1.
- R2: If the clamped vector length is 0 or 1, or none of the rd, rs1 and rs2 fields is tagged, the instruction is pushed exactly once with every field unchanged. This happens without waiting for pred_rdy.
- R3: A register field is tagged when bit N of vec_tag is 1, where N is that field's register number. The tag table is sampled in the accept cycle. In a vectorised run, element i carries tagged fields equal to base+i modulo 2^REG_W, while untagged fields and the opcode are left unchanged.
- R4: In a vectorised run, element i is pushed only when bit i of the captured predicate mask is 1. Enabled elements are pushed in ascending index order.
- R5: A vectorised run pushes nothing until pred_rdy has been sampled high. The mask is captured on the first clock edge at which pred_rdy is high.
- R6: Changes to pred_mask after it has been captured do not affect the current run.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_op, out_rd, out_rs1 and out_rs2 do not change.
- R8: After the last pushed element's handshake, pc_adv is 1 for exactly one cycle, out_valid is 0 and in_ready is 1. pc_adv never rises while an expected element is still unpushed.
- R9: If the captured mask has no enabled bit below the vector length, no element is pushed and pc_adv pulses in the cycle after the capture.
- R10: A vector length above MAX_VL is treated as MAX_VL. Mask bits at or above the effective vector length are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_ready | output | 1 | Expander idle, instruction accepted this cycle if valid |
| in_op | input | OP_W | Opcode and non-register fields |
| in_rd | input | REG_W | Destination register number |
| in_rs1 | input | REG_W | First source register number |
| in_rs2 | input | REG_W | Second source register number |
| vec_tag | input | NUM_REGS | One bit per register, 1 = vectorised |
| vl | input | VL_W | Requested vector length |
| pred_mask | input | MAX_VL | Predicate register value, bit i enables element i |
| pred_rdy | input | 1 | Scoreboard flag: predicate register written |
| out_valid | output | 1 | Element instruction offered to FIFO |
| out_ready | input | 1 | FIFO can take an entry |
| out_op | output | OP_W | Element opcode |
| out_rd | output | REG_W | Element destination register |
| out_rs1 | output | REG_W | Element first source register |
| out_rs2 | output | REG_W | Element second source register |
| pc_adv | output | 1 | One-cycle pulse: instruction fully issued, advance PC |

## Verification
The expansion is tried with directed patterns and then with random ones. Zero and unit vector lengths, and untagged fields with a long length, separate the pass-through path from the vector path. Full, empty, single-last-bit and sparse masks separate the skipping search from a plain counter and expose off-by-one ends. A length above the maximum, with junk bits above the length, shows the clamp. Register numbers near the top of the file show the modulo wrap. Random FIFO backpressure, delayed predicate readiness and a mask scrambled after capture tell a design that holds state from one that re-reads live inputs.

// File: rtl/vx_pkg.sv
package vx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EMIT = 2'd2
  } vx_state_e;

endpackage

// File: rtl/vx_tag_lookup.sv
module vx_tag_lookup #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int MAX_VL   = 16,
  parameter int VL_W     = 5
) (
  input  logic [REG_W-1:0]    rd,
  input  logic [REG_W-1:0]    rs1,
  input  logic [REG_W-1:0]    rs2,
  input  logic [NUM_REGS-1:0] vec_tag,
  input  logic [VL_W-1:0]     vl,
  output logic                t_rd,
  output logic                t_rs1,
  output logic                t_rs2,
  output logic                is_vec,
  output logic [MAX_VL-1:0]   vl_mask
);

  localparam logic [VL_W-1:0] VL_CAP = VL_W'(MAX_VL);

  logic [VL_W-1:0] eff_vl;

  assign eff_vl = (vl > VL_CAP) ? VL_CAP : vl;
  assign t_rd   = vec_tag[rd];
  assign t_rs1  = vec_tag[rs1];
  assign t_rs2  = vec_tag[rs2];
  assign is_vec = (eff_vl > VL_W'(1)) && (t_rd || t_rs1 || t_rs2);

  for (genvar i = 0; i < MAX_VL; i++) begin : g_vlm
    assign vl_mask[i] = (VL_W'(i) < eff_vl);
  end

endmodule

// File: rtl/vx_find_next.sv
module vx_find_next #(
  parameter int N    = 16,
  parameter int IDXW = 4
) (
  input  logic [N-1:0]    mask,
  input  logic [IDXW-1:0] from,
  input  logic            incl,
  output logic            found,
  output logic [IDXW-1:0] pos
);

  logic [N-1:0] cand;

  for (genvar i = 0; i < N; i++) begin : g_cand
    assign cand[i] = mask[i] && (incl || (IDXW'(i) > from));
  end

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        pos   = IDXW'(i);
      end
    end
  end

endmodule

// File: rtl/vx_elem_build.sv
module vx_elem_build #(
  parameter int REG_W = 5,
  parameter int IDXW  = 4
) (
  input  logic [REG_W-1:0] b_rd,
  input  logic [REG_W-1:0] b_rs1,
  input  logic [REG_W-1:0] b_rs2,
  input  logic             t_rd,
  input  logic             t_rs1,
  input  logic             t_rs2,
  input  logic [IDXW-1:0]  idx,
  output logic [REG_W-1:0] e_rd,
  output logic [REG_W-1:0] e_rs1,
  output logic [REG_W-1:0] e_rs2
);

  logic [REG_W-1:0] step;

  assign step  = REG_W'(idx);
  assign e_rd  = t_rd  ? (b_rd  + step) : b_rd;
  assign e_rs1 = t_rs1 ? (b_rs1 + step) : b_rs1;
  assign e_rs2 = t_rs2 ? (b_rs2 + step) : b_rs2;

endmodule

// File: rtl/vec_elem_expander.sv
module vec_elem_expander
  import vx_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int MAX_VL   = 16,
  parameter int VL_W     = $clog2(MAX_VL + 1),
  parameter int OP_W     = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [REG_W-1:0]    in_rd,
  input  logic [REG_W-1:0]    in_rs1,
  input  logic [REG_W-1:0]    in_rs2,
  input  logic [NUM_REGS-1:0] vec_tag,
  input  logic [VL_W-1:0]     vl,
  input  logic [MAX_VL-1:0]   pred_mask,
  input  logic                pred_rdy,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [OP_W-1:0]     out_op,
  output logic [REG_W-1:0]    out_rd,
  output logic [REG_W-1:0]    out_rs1,
  output logic [REG_W-1:0]    out_rs2,
  output logic                pc_adv
);

  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

  vx_state_e state;

  // captured instruction
  logic [OP_W-1:0]   b_op;
  logic [REG_W-1:0]  b_rd, b_rs1, b_rs2;
  logic              b_trd, b_trs1, b_trs2;
  logic [MAX_VL-1:0] b_vlmask;
  logic [MAX_VL-1:0] b_mask;
  logic [IDXW-1:0]   cur_idx;

  // registered outputs
  logic              o_valid;
  logic [OP_W-1:0]   o_op;
  logic [REG_W-1:0]  o_rd, o_rs1, o_rs2;
  logic              o_adv;

  // lookup of incoming instruction
  logic              l_trd, l_trs1, l_trs2, l_vec;
  logic [MAX_VL-1:0] l_vlmask;

  vx_tag_lookup #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .MAX_VL   (MAX_VL),
    .VL_W     (VL_W)
  ) u_lookup (
    .rd      (in_rd),
    .rs1     (in_rs1),
    .rs2     (in_rs2),
    .vec_tag (vec_tag),
    .vl      (vl),
    .t_rd    (l_trd),
    .t_rs1   (l_trs1),
    .t_rs2   (l_trs2),
    .is_vec  (l_vec),
    .vl_mask (l_vlmask)
  );

  // first enabled element of the mask being captured
  logic [MAX_VL-1:0] live_mask;
  logic              first_found;
  logic [IDXW-1:0]   first_pos;

  assign live_mask = pred_mask & b_vlmask;

  vx_find_next #(
    .N    (MAX_VL),
    .IDXW (IDXW)
  ) u_first (
    .mask  (live_mask),
    .from  ('0),
    .incl  (1'b1),
    .found (first_found),
    .pos   (first_pos)
  );

  // next enabled element after the current one
  logic            next_found;
  logic [IDXW-1:0] next_pos;

  vx_find_next #(
    .N    (MAX_VL),
    .IDXW (IDXW)
  ) u_next (
    .mask  (b_mask),
    .from  (cur_idx),
    .incl  (1'b0),
    .found (next_found),
    .pos   (next_pos)
  );

  // element register numbers for the index about to be loaded
  logic [IDXW-1:0]  bld_idx;
  logic [REG_W-1:0] e_rd, e_rs1, e_rs2;

  assign bld_idx = (state == ST_WAIT) ? first_pos : next_pos;

  vx_elem_build #(
    .REG_W (REG_W),
    .IDXW  (IDXW)
  ) u_build (
    .b_rd  (b_rd),
    .b_rs1 (b_rs1),
    .b_rs2 (b_rs2),
    .t_rd  (b_trd),
    .t_rs1 (b_trs1),
    .t_rs2 (b_trs2),
    .idx   (bld_idx),
    .e_rd  (e_rd),
    .e_rs1 (e_rs1),
    .e_rs2 (e_rs2)
  );

  assign in_ready = (state == ST_IDLE);

  // control and datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      b_op     <= '0;
      b_rd     <= '0;
      b_rs1    <= '0;
      b_rs2    <= '0;
      b_trd    <= 1'b0;
      b_trs1   <= 1'b0;
      b_trs2   <= 1'b0;
      b_vlmask <= '0;
      b_mask   <= '0;
      cur_idx  <= '0;
      o_valid  <= 1'b0;
      o_op     <= '0;
      o_rd     <= '0;
      o_rs1    <= '0;
      o_rs2    <= '0;
      o_adv    <= 1'b0;
    end else begin
      o_adv <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            b_op   <= in_op;
            b_rd   <= in_rd;
            b_rs1  <= in_rs1;
            b_rs2  <= in_rs2;
            b_trd  <= l_trd;
            b_trs1 <= l_trs1;
            b_trs2 <= l_trs2;
            if (l_vec) begin
              b_vlmask <= l_vlmask;
              state    <= ST_WAIT;
            end else begin
              // single pass-through element at index zero
              b_vlmask <= MAX_VL'(1);
              b_mask   <= MAX_VL'(1);
              cur_idx  <= '0;
              o_valid  <= 1'b1;
              o_op     <= in_op;
              o_rd     <= in_rd;
              o_rs1    <= in_rs1;
              o_rs2    <= in_rs2;
              state    <= ST_EMIT;
            end
          end
        end
        ST_WAIT: begin
          if (pred_rdy) begin
            b_mask <= live_mask;
            if (first_found) begin
              cur_idx <= first_pos;
              o_valid <= 1'b1;
              o_op    <= b_op;
              o_rd    <= e_rd;
              o_rs1   <= e_rs1;
              o_rs2   <= e_rs2;
              state   <= ST_EMIT;
            end else begin
              o_adv <= 1'b1;
              state <= ST_IDLE;
            end
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (next_found) begin
              cur_idx <= next_pos;
              o_rd    <= e_rd;
              o_rs1   <= e_rs1;
              o_rs2   <= e_rs2;
            end else begin
              o_valid <= 1'b0;
              o_adv   <= 1'b1;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = o_valid;
  assign out_op    = o_op;
  assign out_rd    = o_rd;
  assign out_rs1   = o_rs1;
  assign out_rs2   = o_rs2;
  assign pc_adv    = o_adv;

  // checks beside the logic they guard
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_op) && $stable(out_rd)
                                   && $stable(out_rs1) && $stable(out_rs2))); // R7

  AST_NO_PUSH_WAITING: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !out_valid); // R5

  AST_ADV_PULSE: assert property (@(posedge clk) disable iff (rst)
    pc_adv |=> !pc_adv); // R8

  AST_ADV_IDLE: assert property (@(posedge clk) disable iff (rst)
    pc_adv |-> (in_ready && !out_valid)); // R8

  AST_ELEM_ENABLED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> b_mask[cur_idx]); // R4

  AST_ELEM_IN_VL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> b_vlmask[cur_idx]); // R10

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EMIT && $past(state == ST_EMIT)) |-> $stable(b_mask)); // R6

endmodule

// File: tb/vec_elem_expander_tb.sv
`timescale 1ns/1ps
module vec_elem_expander_tb;

  localparam int NR  = 32;
  localparam int RW  = 5;
  localparam int MVL = 16;
  localparam int VW  = 5;
  localparam int OW  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [OW-1:0] in_op = '0;
  logic [RW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [NR-1:0] vec_tag = '0;
  logic [VW-1:0] vl = '0;
  logic [MVL-1:0] pred_mask = '0;
  logic          pred_rdy = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [OW-1:0] out_op;
  logic [RW-1:0] out_rd, out_rs1, out_rs2;
  logic          pc_adv;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  vec_elem_expander #(
    .NUM_REGS (NR), .REG_W (RW), .MAX_VL (MVL), .VL_W (VW), .OP_W (OW)
  ) u_dut (
    .clk (clk), .rst (rst),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_op (in_op), .in_rd (in_rd), .in_rs1 (in_rs1), .in_rs2 (in_rs2),
    .vec_tag (vec_tag), .vl (vl),
    .pred_mask (pred_mask), .pred_rdy (pred_rdy),
    .out_valid (out_valid), .out_ready (out_ready),
    .out_op (out_op), .out_rd (out_rd), .out_rs1 (out_rs1), .out_rs2 (out_rs2),
    .pc_adv (pc_adv)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int clamp_vl(input int v);
    return (v > MVL) ? MVL : v;
  endfunction

  // expected element list
  logic [RW-1:0] ex_rd [MVL];
  logic [RW-1:0] ex_rs1[MVL];
  logic [RW-1:0] ex_rs2[MVL];
  int            nexp;

  task automatic run_instr(input logic [OW-1:0] op, input logic [RW-1:0] rd,
                           input logic [RW-1:0] rs1, input logic [RW-1:0] rs2,
                           input logic [NR-1:0] tags, input logic [VW-1:0] v,
                           input logic [MVL-1:0] mask, input int pdelay,
                           input int rdy_pct, input string req);
    int  eff;
    bit  vec;
    int  k;
    int  cyc;
    bit  pred_given;
    bit  done;
    bit  hold;
    logic [OW-1:0] h_op;
    logic [RW-1:0] h_rd, h_rs1, h_rs2;
    eff  = clamp_vl(int'(v));
    vec  = (eff > 1) && (tags[rd] || tags[rs1] || tags[rs2]);
    nexp = 0;
    if (!vec) begin
      ex_rd[0] = rd; ex_rs1[0] = rs1; ex_rs2[0] = rs2; nexp = 1;
    end else begin
      for (int i = 0; i < eff; i++) begin
        if (mask[i]) begin
          ex_rd[nexp]  = tags[rd]  ? RW'(int'(rd)  + i) : rd;
          ex_rs1[nexp] = tags[rs1] ? RW'(int'(rs1) + i) : rs1;
          ex_rs2[nexp] = tags[rs2] ? RW'(int'(rs2) + i) : rs2;
          nexp++;
        end
      end
    end

    @(negedge clk);
    chk("R8", {req, " pc_adv low one cycle after pulse"}, int'(pc_adv), 0);
    chk("R8", {req, " in_ready before accept"}, int'(in_ready), 1);
    in_valid  = 1'b1;
    in_op = op; in_rd = rd; in_rs1 = rs1; in_rs2 = rs2;
    vec_tag   = tags;
    vl        = v;
    pred_rdy  = 1'b0;
    pred_mask = MVL'($urandom);
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // R3: tag table and length are sampled only at accept
    vec_tag = $urandom;
    vl      = VW'($urandom);
    in_rd   = RW'($urandom);
    k = 0; cyc = 0; pred_given = 0; done = 0; hold = 0;
    h_op = '0; h_rd = '0; h_rs1 = '0; h_rs2 = '0;
    while (!done && cyc < 400) begin
      if (hold) begin
        chk("R7", {req, " valid held under backpressure"}, int'(out_valid), 1);
        chk("R7", {req, " rd stable"}, int'(out_rd), int'(h_rd));
        chk("R7", {req, " rs1/rs2/op stable"},
            int'({out_op, out_rs1, out_rs2}), int'({h_op, h_rs1, h_rs2}));
        hold = 0;
      end
      if (pc_adv) begin
        chk("R8", {req, " elements pushed before pc_adv"}, k, nexp);
        chk("R8", {req, " in_ready with pc_adv"}, int'(in_ready), 1);
        chk("R9", {req, " out_valid low at pc_adv"}, int'(out_valid), 0);
        done = 1;
      end else begin
        if (out_valid && vec && !pred_given)
          chk("R5", {req, " push before predicate ready"}, 1, 0);
        if (out_valid && k >= nexp)
          chk("R4", {req, " extra element offered"}, k + 1, nexp);
        if (vec && !pred_given && cyc >= pdelay) begin
          pred_rdy   = 1'b1;
          pred_mask  = mask;
          pred_given = 1;
        end else if (pred_given) begin
          pred_mask = MVL'($urandom); // R6
        end
        out_ready = (($urandom % 100) < rdy_pct);
        if (out_valid && out_ready && k < nexp) begin
          chk("R2", {req, " opcode unchanged"}, int'(out_op), int'(op));
          chk("R3", {req, " element rd"}, int'(out_rd), int'(ex_rd[k]));
          chk("R3", {req, " element rs1"}, int'(out_rs1), int'(ex_rs1[k]));
          chk("R4", {req, " element rs2"}, int'(out_rs2), int'(ex_rs2[k]));
          k++;
        end
        if (out_valid && !out_ready) begin
          hold = 1;
          h_op = out_op; h_rd = out_rd; h_rs1 = out_rs1; h_rs2 = out_rs2;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
      end
    end
    if (!done) chk("R8", {req, " instruction never finished"}, 0, 1);
    pred_rdy  = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "pc_adv after reset", int'(pc_adv), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);

    // R2: scalar forms, pred_rdy never raised
    run_instr(12'h0A1, 5'd3, 5'd4, 5'd5, 32'hFFFF_FFFF, 5'd1, 16'h0000, 0, 100, "R2 vl1");
    run_instr(12'h0A2, 5'd7, 5'd8, 5'd9, 32'hFFFF_FFFF, 5'd0, 16'h0000, 0, 60, "R2 vl0");
    run_instr(12'h0A3, 5'd1, 5'd2, 5'd6, 32'h0000_0000, 5'd8, 16'hFFFF, 0, 100, "R2 untagged");
    // R3/R4: full mask, mixed tags
    run_instr(12'h1B0, 5'd10, 5'd11, 5'd12, 32'h0000_0C00, 5'd16, 16'hFFFF, 0, 100, "R3 full");
    // R9: empty mask
    run_instr(12'h1B1, 5'd2, 5'd3, 5'd4, 32'h0000_001C, 5'd8, 16'h0000, 2, 100, "R9 empty");
    // R10: clamp and junk above length
    run_instr(12'h1B2, 5'd0, 5'd16, 5'd20, 32'h0001_0001, 5'd31, 16'hFFFF, 1, 100, "R10 clamp");
    run_instr(12'h1B3, 5'd5, 5'd6, 5'd7, 32'h0000_00E0, 5'd4, 16'hFFF0, 0, 100, "R10 junk");
    // R3: wrap at top of file
    run_instr(12'h1B4, 5'd30, 5'd29, 5'd1, 32'h6000_0000, 5'd5, 16'h001F, 0, 100, "R3 wrap");
    // R4: only last element enabled, sparse
    run_instr(12'h1B5, 5'd8, 5'd9, 5'd10, 32'h0000_0100, 5'd6, 16'h0020, 3, 100, "R4 last");
    run_instr(12'h1B6, 5'd12, 5'd0, 5'd14, 32'h0000_5000, 5'd16, 16'h8421, 0, 50, "R4 sparse");
    // R5/R7: long predicate wait and heavy backpressure
    run_instr(12'h1B7, 5'd4, 5'd4, 5'd4, 32'h0000_0010, 5'd7, 16'h006D, 20, 25, "R5 wait");

    for (int n = 0; n < 60; n++) begin
      run_instr(OW'($urandom), RW'($urandom), RW'($urandom), RW'($urandom),
                $urandom & $urandom, VW'($urandom % 20), MVL'($urandom),
                int'($urandom % 5), 30 + int'($urandom % 71), "R4 random");
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule